// File: doc/BRIEF.md
# Read-Disturb Block Refresh Monitor

This block keeps one read counter per flash block and snoops the flash command bus. Each read command adds one to the counter of the block it names, and each erase command returns that block's counter to zero. When a counter climbs strictly above a programmable limit, the block is marked as needing a refresh. The monitor then raises a single request naming it, so that a controller can move the block's data to a fresh block, erase the original and give it back to the free pool.

Only one request is outstanding at a time. Other blocks that cross the limit wait their turn, and the lowest block index always goes next. Once a block has been requested, it raises no new request until an erase of that block is seen on the command bus. The limit register may be rewritten at any moment.

Top module: `rdm_monitor`

## Requirements
- R1: A command with `cmd_valid` high and `cmd_op` = 2'b01 (read) adds one to the counter of block `cmd_blk` only; no other block's counter moves.
- R2: When a block's counter becomes strictly greater than the limit, the block is marked one cycle after the edge that stored the count. If no request is outstanding, `req_valid` rises with `req_blk` naming that block one edge later. A count equal to the limit raises nothing.
- R3: A counter holds at its all-ones maximum instead of wrapping when further reads arrive.
- R4: An erase command (`cmd_op` = 2'b10) sets the named block's counter to zero and drops any pending or issued refresh state for that block.
- R5: `req_valid` and `req_blk` hold steady until `req_ack` is high while `req_valid` is high; `req_valid` is low after that edge. An acknowledge with no request outstanding has no effect.
- R6: At most one request is outstanding. Blocks waiting for a request are served lowest block index first, whatever the order in which they crossed the limit.
- R7: A block whose request has been issued raises no further request, however many more reads it sees, until it has been erased.
- R8: A write of `cfg_limit` with `cfg_we` high takes effect in the comparison made in the cycle after the write edge, and it applies to counts already stored.
- R9: Commands with `cmd_op` = 2'b00 or 2'b11 are ignored. After reset every counter is zero, the limit equals `LIM_RST`, and `req_valid` and `req_blk` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A snooped command is on the bus this cycle |
| cmd_op | input | 2 | Command kind: 01 read, 10 erase, others ignored |
| cmd_blk | input | BLK_W | Block addressed by the command |
| cfg_we | input | 1 | Write strobe for the limit register |
| cfg_limit | input | CNT_W | New read limit |
| req_valid | output | 1 | A refresh request is outstanding |
| req_blk | output | BLK_W | Block to be refreshed |
| req_ack | input | 1 | Controller has finished with the current request |

## Verification
The assertions assume that `cmd_blk` names an existing block (NUM_BLKS is a power of two). They also assume that `req_ack` is only meaningful while a request is outstanding, and that the controller erases a block before or around the time it acknowledges that block's request. The stimulus uses a four-block, four-bit-counter build. It only ever addresses blocks 0 to 3 and raises the acknowledge for single cycles. It also sends one deliberate acknowledge while idle to show that an acknowledge with nothing outstanding is ignored.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } rdm_op_e;
endpackage

// File: rtl/rdm_blk_ctr.sv
// One block's read counter plus its refresh state (pending / issued).
module rdm_blk_ctr #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_hit,
    input  logic             er_hit,
    input  logic             grant,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             pend,
    output logic             busy
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic             busy;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_hit && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (!st_q.pend && !st_q.busy && (st_q.cnt > limit)) begin
            st_d.pend = 1'b1;
        end
        if (grant) begin
            st_d.pend = 1'b0;
            st_d.busy = 1'b1;
        end
        if (er_hit) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign pend = st_q.pend;
    assign busy = st_q.busy;
endmodule

// File: rtl/rdm_pick.sv
// Lowest-index selector over a request vector.
module rdm_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rdm_monitor.sv
module rdm_monitor #(
    parameter int NUM_BLKS = 8,
    parameter int CNT_W    = 20,
    parameter int LIM_RST  = 200000,
    localparam int BLK_W   = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [BLK_W-1:0] cmd_blk,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_limit,
    output logic             req_valid,
    output logic [BLK_W-1:0] req_blk,
    input  logic             req_ack
);
    import rdm_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] limit;
        logic             rv;
        logic [BLK_W-1:0] rb;
    } top_t;

    top_t s_d, s_q;

    logic                            is_rd, is_er;
    logic [NUM_BLKS-1:0]             rd_vec, er_vec, grant_vec;
    logic [NUM_BLKS-1:0]             pend_vec, busy_vec, cand_vec;
    logic [NUM_BLKS-1:0][CNT_W-1:0]  cnt_vec;
    logic                            pick_ok, issue;
    logic [BLK_W-1:0]                pick_idx;

    assign is_rd = cmd_valid && (rdm_op_e'(cmd_op) == OP_READ);
    assign is_er = cmd_valid && (rdm_op_e'(cmd_op) == OP_ERASE);

    // an erase landing in the same cycle wins over issuing that block
    assign cand_vec = pend_vec & ~er_vec;
    assign issue    = !s_q.rv && pick_ok;

    for (genvar g = 0; g < NUM_BLKS; g++) begin : g_blk
        assign rd_vec[g]    = is_rd && (cmd_blk == BLK_W'(g));
        assign er_vec[g]    = is_er && (cmd_blk == BLK_W'(g));
        assign grant_vec[g] = issue && (pick_idx == BLK_W'(g));

        rdm_blk_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_hit (rd_vec[g]),
            .er_hit (er_vec[g]),
            .grant  (grant_vec[g]),
            .limit  (s_q.limit),
            .cnt    (cnt_vec[g]),
            .pend   (pend_vec[g]),
            .busy   (busy_vec[g])
        );
    end

    rdm_pick #(.N(NUM_BLKS)) u_pick (
        .vec   (cand_vec),
        .found (pick_ok),
        .idx   (pick_idx)
    );

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            s_d.limit = cfg_limit;
        end
        if (s_q.rv && req_ack) begin
            s_d.rv = 1'b0;
        end
        if (issue) begin
            s_d.rv = 1'b1;
            s_d.rb = pick_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.limit <= CNT_W'(LIM_RST);
            s_q.rv    <= 1'b0;
            s_q.rb    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_valid = s_q.rv;
    assign req_blk   = s_q.rb;
endmodule

// File: rtl/rdm_monitor_chk.sv
module rdm_monitor_chk #(
    parameter int NUM_BLKS = 8,
    parameter int CNT_W    = 20,
    parameter int BLK_W    = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cmd_valid,
    input logic [1:0]                     cmd_op,
    input logic [BLK_W-1:0]               cmd_blk,
    input logic                           req_valid,
    input logic [BLK_W-1:0]               req_blk,
    input logic                           req_ack,
    input logic [NUM_BLKS-1:0][CNT_W-1:0] cnt_vec,
    input logic [NUM_BLKS-1:0]            pend_vec,
    input logic [NUM_BLKS-1:0]            busy_vec
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_blk)));

    // R5
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_valid);

    // R4
    erase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b10) |=> (cnt_vec[$past(cmd_blk)] == '0));

    // R3
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b01 && cnt_vec[cmd_blk] == CMAX) |=> (cnt_vec[$past(cmd_blk)] == CMAX));

    // R6
    issue_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> (busy_vec[req_blk] && !pend_vec[req_blk]));

    // R7
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_vec & busy_vec) == '0));
endmodule

bind rdm_monitor rdm_monitor_chk #(
    .NUM_BLKS(NUM_BLKS),
    .CNT_W   (CNT_W),
    .BLK_W   (BLK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_blk   (cmd_blk),
    .req_valid (req_valid),
    .req_blk   (req_blk),
    .req_ack   (req_ack),
    .cnt_vec   (cnt_vec),
    .pend_vec  (pend_vec),
    .busy_vec  (busy_vec)
);

// File: tb/sim_rdm_monitor.sv
module sim_rdm_monitor;
    localparam int NB = 4;
    localparam int CW = 4;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [BW-1:0] cmd_blk = '0;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_limit = '0;
    logic          req_valid;
    logic [BW-1:0] req_blk;
    logic          req_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rdm_monitor #(.NUM_BLKS(NB), .CNT_W(CW), .LIM_RST(3)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .cfg_we(cfg_we), .cfg_limit(cfg_limit),
        .req_valid(req_valid), .req_blk(req_blk), .req_ack(req_ack)
    );

    // op, blk, ack, expected valid, expected block, requirement number
    typedef struct packed {
        logic [1:0] op;
        logic [1:0] blk;
        logic       ack;
        logic       rv;
        logic [1:0] rb;
        logic [3:0] rq;
    } vec_t;

    localparam vec_t TBL [0:29] = '{
        '{2'b01, 2'd2, 1'b0, 1'b0, 2'd0, 4'd1},   // R1 b2=1
        '{2'b01, 2'd2, 1'b0, 1'b0, 2'd0, 4'd1},   // b2=2
        '{2'b01, 2'd2, 1'b0, 1'b0, 2'd0, 4'd2},   // b2=3 equals limit
        '{2'b01, 2'd2, 1'b0, 1'b0, 2'd0, 4'd2},   // b2=4
        '{2'b11, 2'd2, 1'b0, 1'b0, 2'd0, 4'd9},   // R9 op 11 ignored; mark set
        '{2'b00, 2'd2, 1'b0, 1'b1, 2'd2, 4'd2},   // R2 request b2
        '{2'b01, 2'd1, 1'b0, 1'b1, 2'd2, 4'd5},
        '{2'b01, 2'd1, 1'b0, 1'b1, 2'd2, 4'd5},
        '{2'b01, 2'd1, 1'b0, 1'b1, 2'd2, 4'd5},
        '{2'b01, 2'd1, 1'b0, 1'b1, 2'd2, 4'd6},   // b1 over limit, queued
        '{2'b01, 2'd0, 1'b0, 1'b1, 2'd2, 4'd6},
        '{2'b01, 2'd0, 1'b0, 1'b1, 2'd2, 4'd6},
        '{2'b01, 2'd0, 1'b0, 1'b1, 2'd2, 4'd6},
        '{2'b01, 2'd0, 1'b0, 1'b1, 2'd2, 4'd6},   // b0 over limit later
        '{2'b00, 2'd0, 1'b1, 1'b0, 2'd0, 4'd5},   // R5 ack drops request
        '{2'b00, 2'd0, 1'b0, 1'b1, 2'd0, 4'd6},   // R6 lowest index first
        '{2'b10, 2'd2, 1'b0, 1'b1, 2'd0, 4'd4},   // R4 erase b2
        '{2'b01, 2'd2, 1'b0, 1'b1, 2'd0, 4'd4},
        '{2'b01, 2'd2, 1'b0, 1'b1, 2'd0, 4'd4},
        '{2'b01, 2'd2, 1'b0, 1'b1, 2'd0, 4'd4},   // b2=3 after erase
        '{2'b01, 2'd0, 1'b0, 1'b1, 2'd0, 4'd7},   // R7 b0 busy
        '{2'b00, 2'd0, 1'b1, 1'b0, 2'd0, 4'd5},
        '{2'b00, 2'd0, 1'b0, 1'b1, 2'd1, 4'd6},   // queued b1 served
        '{2'b00, 2'd0, 1'b1, 1'b0, 2'd0, 4'd5},
        '{2'b00, 2'd0, 1'b0, 1'b0, 2'd0, 4'd7},   // R7 no repeat for b0
        '{2'b00, 2'd0, 1'b1, 1'b0, 2'd0, 4'd5},   // ack while idle ignored
        '{2'b01, 2'd2, 1'b0, 1'b0, 2'd0, 4'd1},   // b2=4
        '{2'b00, 2'd0, 1'b0, 1'b0, 2'd0, 4'd2},
        '{2'b00, 2'd0, 1'b0, 1'b1, 2'd2, 4'd2},   // erased b2 re-requested
        '{2'b00, 2'd0, 1'b1, 1'b0, 2'd0, 4'd5}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        cmd_valid = 1'b0; req_ack = 1'b0; cfg_we = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 reset valid", int'(req_valid), 0);
        check("R9 reset blk", int'(req_blk), 0);

        for (int i = 0; i < 30; i++) begin
            cmd_valid = !TBL[i].ack;
            cmd_op    = TBL[i].op;
            cmd_blk   = TBL[i].blk;
            req_ack   = TBL[i].ack;
            @(negedge clk);
            check($sformatf("R%0d step %0d valid", TBL[i].rq, i), int'(req_valid), int'(TBL[i].rv));
            if (TBL[i].rv)
                check($sformatf("R%0d step %0d blk", TBL[i].rq, i), int'(req_blk), int'(TBL[i].rb));
        end
        idle(1);

        // R3 / R8: saturate b3 at limit 15, then lower the limit
        cfg_we = 1'b1; cfg_limit = 4'd15;
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_blk = 2'd3;
        @(negedge clk);
        cfg_we = 1'b0;
        for (int k = 0; k < 20; k++) begin
            cmd_valid = 1'b1; cmd_op = 2'b01; cmd_blk = 2'd3;
            @(negedge clk);
        end
        idle(3);
        check("R3 saturated at max, no request", int'(req_valid), 0);
        cfg_we = 1'b1; cfg_limit = 4'd14;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R8 write edge", int'(req_valid), 0);
        @(negedge clk);
        check("R8 mark cycle", int'(req_valid), 0);
        @(negedge clk);
        check("R3 request after limit drop", int'(req_valid), 1);
        check("R8 request blk", int'(req_blk), 3);

        // R9 reset clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 reset mid-run", int'(req_valid), 0);
        idle(3);
        check("R9 counters cleared", int'(req_valid), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule